// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write path of a parallel NOR-style flash array. It watches bus write cycles, each carrying an address and a data word, and recognises the command sequences the array accepts: a two-cycle unlock prefix, then a program, autoselect or unlock-bypass command, plus the reset command. It reports which mode the array interface is in (read-array, autoselect or bypass). When a program sequence completes, it raises a one-cycle start pulse toward the external program engine and holds the target address and data for it.

In autoselect mode the block also drives the identification data for reads. This can be the manufacturer code, the device code, or the protect status of the sector the read address falls in, and it honours byte or word addressing of the offsets. While the program engine reports busy, every write is dropped. Erase operations and array storage live elsewhere; erase activity reaches this block only through the busy input.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the read-array flag is high, the autoselect and bypass flags are low and no program pulse is raised; at every cycle exactly one of the three mode flags is high.
- R2: Writes of AAh at word address 555h, 55h at 2AAh, A0h at 555h, then any address and data raise `prog_start` for exactly one cycle, in the cycle after that last write, with `prog_addr`/`prog_data` equal to that write; the block then shows read-array. Addresses are matched on `wr_addr[10:0]` and commands on `wr_data[7:0]`.
- R3: A write that does not match the expected unlock or command cycle returns the decoder to idle, so later writes are not taken as the rest of the broken sequence.
- R4: A write of F0h at any address, made after any cycle of a program or autoselect sequence and before the final cycle, aborts the sequence and returns to read-array.
- R5: While `busy_in` is high a write is ignored completely, F0h included: no mode change, no partial sequence progress, no program pulse.
- R6: AAh@555h, 55h@2AAh, 90h@555h enter autoselect mode; it persists over any number of reads and over writes other than F0h, and only F0h at any address leaves it for read-array.
- R7: In autoselect with `byte_mode` low, the read offset (the `rd_addr` bits below the top `SECT_BITS` bits) 0 returns the manufacturer code, 1 the device code, 2 returns 1 if `sect_prot[sector]` is set and 0 otherwise (sector = top `SECT_BITS` bits of `rd_addr`), and any other offset returns 0.
- R8: With `byte_mode` high the device code moves to offset 2 and the protect status to offset 4; offset 0 is still the manufacturer code and offset 1 returns 0.
- R9: AAh@555h, 55h@2AAh, 20h@555h enter bypass mode and raise the bypass flag.
- R10: In bypass mode, A0h at any address followed by one more write raises the program pulse with that write's address and data (whatever the data, F0h included), and the block stays in bypass.
- R11: In bypass mode every write other than A0h or 90h is ignored, including F0h and the standard unlock cycles.
- R12: In bypass mode, 90h then 00h at any addresses return to read-array; 90h followed by any other data returns to plain bypass without leaving it.
- R13: Outside autoselect mode `rd_id_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write cycle strobe, one cycle per write |
| wr_addr | input | AW | Write word address |
| wr_data | input | DW | Write data |
| busy_in | input | 1 | Program or erase engine running; writes are dropped |
| byte_mode | input | 1 | Selects byte-style autoselect offsets |
| rd_addr | input | AW | Read address for autoselect data |
| sect_prot | input | 2**SECT_BITS | Protect status, one bit per sector |
| mode_read | output | 1 | Read-array mode |
| mode_auto | output | 1 | Autoselect mode |
| mode_bypass | output | 1 | Unlock-bypass mode |
| prog_start | output | 1 | One-cycle program request |
| prog_addr | output | AW | Latched program address |
| prog_data | output | DW | Latched program data |
| rd_id_data | output | DW | Autoselect read data, zero otherwise |

## Verification
The bench aims at the places where sequence tracking goes wrong. These are an unlock with the wrong second address, an F0h after the set-up command, and a full program sequence issued while busy; a decoder that kept partial progress would emit a stray program pulse on a later write. In bypass it sends F0h, a fresh unlock prefix, and 90h followed by non-zero data; a design that obeyed any of these would drop out of bypass or enter autoselect. Autoselect reads sweep both offset layouts and protected and unprotected sectors, so a swapped byte-mode offset or a wrong sector slice shows up as a wrong code.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
   localparam int UNLOCK_AW = 11;
   localparam logic [UNLOCK_AW-1:0] ADDR_KEY_A = 11'h555;
   localparam logic [UNLOCK_AW-1:0] ADDR_KEY_B = 11'h2AA;

   localparam logic [7:0] CMD_KEY_A  = 8'hAA;
   localparam logic [7:0] CMD_KEY_B  = 8'h55;
   localparam logic [7:0] CMD_PROG   = 8'hA0;
   localparam logic [7:0] CMD_IDENT  = 8'h90;
   localparam logic [7:0] CMD_BYPASS = 8'h20;
   localparam logic [7:0] CMD_ABORT  = 8'hF0;
   localparam logic [7:0] CMD_BYP_Q  = 8'h00;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_KEY1,
      ST_KEY2,
      ST_PSET,
      ST_IDENT,
      ST_BYP,
      ST_BPGM,
      ST_BEXIT
   } fcd_state_t;
endpackage

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
   import fcd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       accept,
   input  logic [7:0] cmd,
   input  logic       at_key_a,
   input  logic       at_key_b,
   output fcd_state_t state,
   output logic       prog_fire
);
   fcd_state_t nxt;

   always_comb begin
      nxt       = state;
      prog_fire = 1'b0;
      if (accept) begin
         case (state)
            ST_IDLE:  if (at_key_a && cmd == CMD_KEY_A) nxt = ST_KEY1;
            ST_KEY1:  nxt = (at_key_b && cmd == CMD_KEY_B) ? ST_KEY2 : ST_IDLE;
            ST_KEY2: begin
               nxt = ST_IDLE;
               if (at_key_a) begin
                  if (cmd == CMD_PROG)        nxt = ST_PSET;
                  else if (cmd == CMD_IDENT)  nxt = ST_IDENT;
                  else if (cmd == CMD_BYPASS) nxt = ST_BYP;
               end
            end
            ST_PSET: begin
               nxt       = ST_IDLE;
               prog_fire = (cmd != CMD_ABORT);
            end
            ST_IDENT: if (cmd == CMD_ABORT) nxt = ST_IDLE;
            ST_BYP: begin
               if (cmd == CMD_PROG)       nxt = ST_BPGM;
               else if (cmd == CMD_IDENT) nxt = ST_BEXIT;
            end
            ST_BPGM: begin
               nxt       = ST_BYP;
               prog_fire = 1'b1;
            end
            ST_BEXIT: nxt = (cmd == CMD_BYP_Q) ? ST_IDLE : ST_BYP;
            default:  nxt = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/fcd_prog_latch.sv
module fcd_prog_latch #(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] addr_in,
   input  logic [DW-1:0] data_in,
   output logic          start,
   output logic [AW-1:0] addr_q,
   output logic [DW-1:0] data_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start  <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         start <= load;
         if (load) begin
            addr_q <= addr_in;
            data_q <= data_in;
         end
      end
   end
endmodule

// File: rtl/fcd_id_mux.sv
module fcd_id_mux #(
   parameter int          AW        = 16,
   parameter int          DW        = 16,
   parameter int          SECT_BITS = 3,
   parameter logic [DW-1:0] MFR_CODE = '0,
   parameter logic [DW-1:0] DEV_CODE = '0,
   localparam int         NSECT     = 1 << SECT_BITS,
   localparam int         OFS_W     = AW - SECT_BITS
) (
   input  logic             active,
   input  logic             byte_mode,
   input  logic [AW-1:0]    rd_addr,
   input  logic [NSECT-1:0] sect_prot,
   output logic [DW-1:0]    id_data
);
   localparam logic [OFS_W-1:0] OFS_MFR  = OFS_W'(0);
   localparam logic [OFS_W-1:0] OFS_W_DV = OFS_W'(1);
   localparam logic [OFS_W-1:0] OFS_W_PR = OFS_W'(2);
   localparam logic [OFS_W-1:0] OFS_B_DV = OFS_W'(2);
   localparam logic [OFS_W-1:0] OFS_B_PR = OFS_W'(4);

   logic [OFS_W-1:0] ofs;
   logic [OFS_W-1:0] dev_ofs;
   logic [OFS_W-1:0] prot_ofs;
   logic             prot_bit;

   assign ofs      = rd_addr[OFS_W-1:0];
   assign dev_ofs  = byte_mode ? OFS_B_DV : OFS_W_DV;
   assign prot_ofs = byte_mode ? OFS_B_PR : OFS_W_PR;

   generate
      if (SECT_BITS == 0) begin : g_one_sector
         assign prot_bit = sect_prot[0];
      end else begin : g_many_sectors
         assign prot_bit = sect_prot[rd_addr[AW-1:OFS_W]];
      end
   endgenerate

   always_comb begin
      id_data = '0;
      if (active) begin
         if (ofs == OFS_MFR)       id_data = MFR_CODE;
         else if (ofs == dev_ofs)  id_data = DEV_CODE;
         else if (ofs == prot_ofs) id_data = {{(DW-1){1'b0}}, prot_bit};
      end
   end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import fcd_pkg::*;
#(
   parameter int            AW        = 16,
   parameter int            DW        = 16,
   parameter int            SECT_BITS = 3,
   parameter logic [DW-1:0] MFR_CODE  = 16'h0001,
   parameter logic [DW-1:0] DEV_CODE  = 16'h22EA,
   localparam int           NSECT     = 1 << SECT_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [DW-1:0]    wr_data,
   input  logic             busy_in,
   input  logic             byte_mode,
   input  logic [AW-1:0]    rd_addr,
   input  logic [NSECT-1:0] sect_prot,
   output logic             mode_read,
   output logic             mode_auto,
   output logic             mode_bypass,
   output logic             prog_start,
   output logic [AW-1:0]    prog_addr,
   output logic [DW-1:0]    prog_data,
   output logic [DW-1:0]    rd_id_data
);
   generate
      if (AW <= UNLOCK_AW) begin : g_bad_aw
         $error("AW must exceed the unlock address width");
      end
      if (DW < 8) begin : g_bad_dw
         $error("DW must hold a command byte");
      end
      if (SECT_BITS < 0 || SECT_BITS > AW - 3) begin : g_bad_sect
         $error("SECT_BITS leaves no room for autoselect offsets");
      end
   endgenerate

   fcd_state_t state;
   logic       accept;
   logic       prog_fire;
   logic       at_key_a;
   logic       at_key_b;

   assign accept   = wr_en && !busy_in;
   assign at_key_a = (wr_addr[UNLOCK_AW-1:0] == ADDR_KEY_A);
   assign at_key_b = (wr_addr[UNLOCK_AW-1:0] == ADDR_KEY_B);

   fcd_seq_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .cmd       (wr_data[7:0]),
      .at_key_a  (at_key_a),
      .at_key_b  (at_key_b),
      .state     (state),
      .prog_fire (prog_fire)
   );

   fcd_prog_latch #(.AW(AW), .DW(DW)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (prog_fire),
      .addr_in (wr_addr),
      .data_in (wr_data),
      .start   (prog_start),
      .addr_q  (prog_addr),
      .data_q  (prog_data)
   );

   assign mode_auto   = (state == ST_IDENT);
   assign mode_bypass = (state == ST_BYP) || (state == ST_BPGM) || (state == ST_BEXIT);
   assign mode_read   = !(mode_auto || mode_bypass);

   fcd_id_mux #(
      .AW(AW), .DW(DW), .SECT_BITS(SECT_BITS),
      .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
   ) u_id (
      .active    (mode_auto),
      .byte_mode (byte_mode),
      .rd_addr   (rd_addr),
      .sect_prot (sect_prot),
      .id_data   (rd_id_data)
   );
endmodule

// File: rtl/fcd_chk.sv
module fcd_chk #(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [AW-1:0] wr_addr,
   input logic [DW-1:0] wr_data,
   input logic          busy_in,
   input logic          mode_read,
   input logic          mode_auto,
   input logic          mode_bypass,
   input logic          prog_start,
   input logic [AW-1:0] prog_addr,
   input logic [DW-1:0] prog_data,
   input logic [DW-1:0] rd_id_data
);
   // R1
   mode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({mode_read, mode_auto, mode_bypass}) == 1);

   // R5
   busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_in |=> ($stable(mode_read) && $stable(mode_auto) && $stable(mode_bypass) && !prog_start));

   // R2
   prog_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |-> $past(wr_en && !busy_in));

   // R2
   prog_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |-> (prog_addr == $past(wr_addr) && prog_data == $past(wr_data)));

   // R6
   auto_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_auto && !(wr_en && !busy_in && wr_data[7:0] == 8'hF0)) |=> mode_auto);

   // R12
   byp_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mode_bypass) |-> $past(wr_en && wr_data[7:0] == 8'h00));

   // R13
   id_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_auto |-> rd_id_data == '0);
endmodule

bind flash_cmd_decoder fcd_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .wr_data     (wr_data),
   .busy_in     (busy_in),
   .mode_read   (mode_read),
   .mode_auto   (mode_auto),
   .mode_bypass (mode_bypass),
   .prog_start  (prog_start),
   .prog_addr   (prog_addr),
   .prog_data   (prog_data),
   .rd_id_data  (rd_id_data)
);

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;
   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] MFR = 16'h0001;
   localparam logic [15:0] DEV = 16'h22EA;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [15:0] wr_addr;
   logic [15:0] wr_data;
   logic        busy_in;
   logic        byte_mode;
   logic [15:0] rd_addr;
   logic [7:0]  sect_prot;
   logic        mode_read, mode_auto, mode_bypass, prog_start;
   logic [15:0] prog_addr, prog_data, rd_id_data;

   int checks = 0;
   int errors = 0;

   flash_cmd_decoder dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .busy_in(busy_in), .byte_mode(byte_mode), .rd_addr(rd_addr), .sect_prot(sect_prot),
      .mode_read(mode_read), .mode_auto(mode_auto), .mode_bypass(mode_bypass),
      .prog_start(prog_start), .prog_addr(prog_addr), .prog_data(prog_data),
      .rd_id_data(rd_id_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // behavioural reference: mode 0 read, 1 autoselect, 2 bypass; queue holds accepted steps
   int          m_mode = 0;
   logic [7:0]  steps[$];
   logic        m_start = 1'b0;
   logic [15:0] m_pa = '0, m_pd = '0;

   function automatic logic [15:0] exp_id(int mode, logic bm, logic [15:0] a, logic [7:0] prot);
      logic [12:0] ofs;
      ofs = a[12:0];
      if (mode != 1) return 16'h0;
      if (ofs == 0) return MFR;
      if (ofs == (bm ? 13'd2 : 13'd1)) return DEV;
      if (ofs == (bm ? 13'd4 : 13'd2)) return {15'h0, prot[a[15:13]]};
      return 16'h0;
   endfunction

   always @(posedge clk) begin
      logic [7:0]  d;
      logic [10:0] a;
      m_start = 1'b0;
      if (!rst_n) begin
         m_mode = 0;
         steps.delete();
      end else if (wr_en && !busy_in) begin
         d = wr_data[7:0];
         a = wr_addr[10:0];
         if (m_mode == 1) begin
            if (d == 8'hF0) m_mode = 0;
         end else if (m_mode == 2) begin
            if (steps.size() == 0) begin
               if (d == 8'hA0 || d == 8'h90) steps.push_back(d);
            end else begin
               if (steps[0] == 8'hA0) begin
                  m_start = 1'b1; m_pa = wr_addr; m_pd = wr_data;
               end else if (d == 8'h00) m_mode = 0;
               steps.delete();
            end
         end else if (d == 8'hF0) begin
            steps.delete();
         end else begin
            case (steps.size())
               0: if (a == 11'h555 && d == 8'hAA) steps.push_back(d);
               1: if (a == 11'h2AA && d == 8'h55) steps.push_back(d); else steps.delete();
               2: if (a == 11'h555 && d == 8'hA0) steps.push_back(d);
                  else begin
                     if (a == 11'h555 && d == 8'h90) m_mode = 1;
                     else if (a == 11'h555 && d == 8'h20) m_mode = 2;
                     steps.delete();
                  end
               default: begin
                  m_start = 1'b1; m_pa = wr_addr; m_pd = wr_data;
                  steps.delete();
               end
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         chk("MODEL mode_read", mode_read, m_mode == 0);
         chk("MODEL mode_auto", mode_auto, m_mode == 1);
         chk("MODEL mode_bypass", mode_bypass, m_mode == 2);
         chk("MODEL prog_start", prog_start, m_start);
         if (m_start) begin
            chk("MODEL prog_addr", prog_addr, m_pa);
            chk("MODEL prog_data", prog_data, m_pd);
         end
         chk("MODEL rd_id_data", rd_id_data, exp_id(m_mode, byte_mode, rd_addr, sect_prot));
      end
   end

   task automatic wr(logic [15:0] a, logic [15:0] d);
      wr_addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic unlock();
      wr(16'h0555, 16'h00AA);
      wr(16'h02AA, 16'h0055);
   endtask

   task automatic rd(string tag, logic [15:0] a, logic [15:0] exp);
      rd_addr = a;
      #1;
      chk(tag, rd_id_data, exp);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; busy_in = 1'b0;
      byte_mode = 1'b0; rd_addr = '0; sect_prot = 8'b0000_1000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 read flag", mode_read, 1);
      chk("R1 auto flag", mode_auto, 0);
      chk("R1 bypass flag", mode_bypass, 0);
      chk("R1 no pulse", prog_start, 0);
      @(negedge clk);

      // R2 standard program
      unlock(); wr(16'h0555, 16'h00A0); wr(16'h1234, 16'h5A5A);
      chk("R2 pulse", prog_start, 1);
      chk("R2 addr", prog_addr, 16'h1234);
      chk("R2 data", prog_data, 16'h5A5A);
      @(negedge clk);
      chk("R2 pulse width", prog_start, 0);
      chk("R2 back to read", mode_read, 1);

      // R3 mismatches
      wr(16'h0555, 16'h00AA); wr(16'h02AB, 16'h0055); wr(16'h0555, 16'h00A0); wr(16'h0100, 16'h1111);
      chk("R3 bad unlock address", prog_start, 0);
      unlock(); wr(16'h0555, 16'h0077); wr(16'h0000, 16'h0090);
      chk("R3 bad command", mode_auto, 0);

      // R4 aborts
      unlock(); wr(16'h0555, 16'h00A0); wr(16'h0000, 16'h00F0); wr(16'h0200, 16'h2222);
      chk("R4 program abort", prog_start, 0);
      wr(16'h0555, 16'h00AA); wr(16'h0000, 16'h00F0); wr(16'h02AA, 16'h0055); wr(16'h0555, 16'h0090);
      chk("R4 autoselect abort", mode_auto, 0);

      // R5 busy
      busy_in = 1'b1;
      unlock(); wr(16'h0555, 16'h00A0); wr(16'h0300, 16'h3333);
      chk("R5 no pulse while busy", prog_start, 0);
      busy_in = 1'b0;
      wr(16'h0300, 16'h3333);
      chk("R5 no partial progress", prog_start, 0);
      unlock(); wr(16'h0555, 16'h0090);
      busy_in = 1'b1; wr(16'h0000, 16'h00F0); busy_in = 1'b0;
      chk("R5 reset ignored while busy", mode_auto, 1);

      // R6 autoselect persists
      wr(16'h0000, 16'h00AA); wr(16'h0000, 16'h00A0);
      chk("R6 stays in autoselect", mode_auto, 1);

      // R7 word-mode map
      rd("R7 manufacturer", 16'h0000, MFR);
      rd("R7 device", 16'h0001, DEV);
      rd("R7 protected sector", 16'h6002, 16'h0001);
      rd("R7 unprotected sector", 16'h4002, 16'h0000);
      rd("R7 other offset", 16'h0005, 16'h0000);
      // R8 byte-mode map
      byte_mode = 1'b1;
      rd("R8 manufacturer", 16'h0000, MFR);
      rd("R8 device", 16'h0002, DEV);
      rd("R8 protected sector", 16'h6004, 16'h0001);
      rd("R8 offset one", 16'h0001, 16'h0000);
      byte_mode = 1'b0;
      rd_addr = 16'h0000;
      @(negedge clk);
      wr(16'h0ABC, 16'h00F0);
      chk("R6 exit on reset", mode_read, 1);
      #1;
      chk("R13 quiet outside autoselect", rd_id_data, 0);
      @(negedge clk);

      // R9 bypass entry
      unlock(); wr(16'h0555, 16'h0020);
      chk("R9 bypass flag", mode_bypass, 1);
      // R10 bypass program
      wr(16'h0000, 16'h00A0); wr(16'h0400, 16'h4444);
      chk("R10 pulse", prog_start, 1);
      chk("R10 addr", prog_addr, 16'h0400);
      chk("R10 data", prog_data, 16'h4444);
      chk("R10 stays bypass", mode_bypass, 1);
      wr(16'h0000, 16'h00A0); wr(16'h0401, 16'h00F0);
      chk("R10 F0 taken as data", prog_data, 16'h00F0);
      // R11 ignored commands
      wr(16'h0000, 16'h00F0);
      chk("R11 reset ignored", mode_bypass, 1);
      wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055);
      chk("R11 unlock ignored", mode_bypass, 1);
      #1;
      chk("R13 quiet in bypass", rd_id_data, 0);
      // R12 exit rules
      wr(16'h0555, 16'h0090); wr(16'h0000, 16'h0055);
      chk("R12 no exit on wrong data", mode_bypass, 1);
      wr(16'h0000, 16'h00A0); wr(16'h0500, 16'h5555);
      chk("R12 still programs after failed exit", prog_start, 1);
      wr(16'h0777, 16'h0090); wr(16'h0123, 16'h0000);
      chk("R12 exit", mode_read, 1);

      repeat (3) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule